// File: doc/BRIEF.md
# Capture Context Frame Controller

This block governs a single capture context of a camera serial receiver. An upstream packet decoder supplies three single-cycle strobes (frame start, line end and frame end) together with the frame identifier carried by the frame-start packet. The controller decides which frames the context accepts. It counts the frames still to be taken, switches itself off when a limited run is exhausted, and raises a line event when a programmed line position is reached. It also keeps the identifier of the frame now being taken.

Software uses a small word-wide register interface. The control fields (on/off, line-event mode, frame quota) and the line-event position are held in pending copies and become active only when the next frame-start strobe arrives. The two event flags and their enables act at once. The interrupt output is high while any flag whose enable is set is high.

The frame tracker is a three-state machine. OFF means the context is disabled. IDLE means it is enabled and between captured frames. CAPT means it is inside a captured frame. The transitions are as follows:
- OFF→CAPT and IDLE→CAPT on a frame start while the pending enable is 1.
- OFF→OFF, IDLE→OFF and CAPT→OFF on a frame start while the pending enable is 0.
- CAPT→CAPT on a frame start while the pending enable is 1.
- CAPT→IDLE on a frame end that leaves the quota non-zero or unlimited.
- CAPT→OFF on a frame end that uses up the quota.
- Every other cycle holds the state.

Top module: `capctx_ctrl`

## Requirements
- R1: After reset the context is off, `capturing`, `irq`, `ev_count` and `ev_line` are low, and every readable register reads 0.
- R2: A write to the control word (address 0) or the line word (address 1) takes effect only at the next `frame_start`. Address 0 has this layout: bit 0 enable, bit 1 line mode, bit 4 count unlock, bits 15:8 frame count. Address 1 holds the line position in bits LINE_W-1:0. Reads of addresses 0 and 1 return the active values in the same layout, and bit 4 reads 0.
- R3: A control write stores bits 15:8 as the new frame count only when bit 4 of the same write is 1. Otherwise the active count is left unchanged.
- R4: When a non-zero count N is active, exactly N frames are captured. The count drops by one at the end of each captured frame. At the end of the Nth frame, `ev_count` pulses for one cycle, status bit 0 is set, and the context turns itself off, so later frames are not captured until it is enabled again.
- R5: An active count of 0 means unlimited capture. The count never changes and no frame-count event is raised.
- R6: A frame already in progress when the context is enabled is ignored, including its line ends and its frame end. Capture begins at the following `frame_start`.
- R7: In line mode 0 with position L>0, `ev_line` pulses once in a captured frame, at the L-th line end of that frame. L=0 never fires. The line count restarts at each `frame_start`.
- R8: In line mode 1 with position L>0, `ev_line` pulses at every line end whose index within the frame is a multiple of L. L=0 never fires.
- R9: At each captured `frame_start` the value on `frame_num_in` is latched. It appears on `frame_id` and at address 4, and a frame that is not captured leaves it unchanged.
- R10: Status (address 2: bit 0 count event, bit 1 line event) is cleared by writing 1 to a bit. Address 3 holds the matching enables. `irq` is high exactly when some status bit and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| frame_start | input | 1 | Frame-start strobe from the decoder |
| frame_end | input | 1 | Frame-end strobe |
| line_end | input | 1 | Line-end strobe |
| frame_num_in | input | FID_W | Frame identifier valid with frame_start |
| capturing | output | 1 | High while inside a captured frame |
| frame_id | output | FID_W | Identifier of the last captured frame |
| ev_count | output | 1 | One-cycle pulse when the frame quota runs out |
| ev_line | output | 1 | One-cycle pulse on a line-position hit |
| irq | output | 1 | Enabled events pending |

## Verification
The bench builds the block with a 6-bit line position and an 8-bit frame identifier, and keeps the 8-bit count. Line positions from 0 through past the frame length can then be swept in both line modes within a few hundred cycles, with the expected number of hits computed as a quotient or a range test. Quotas from 1 to 4 are each run to exhaustion, with extra frames afterwards to show that the context stays off.

// File: rtl/capctx_pkg.sv
package capctx_pkg;
    typedef enum logic [1:0] {S_OFF, S_IDLE, S_CAPT} cap_state_e;

    localparam int A_CTRL = 0;
    localparam int A_LINE = 1;
    localparam int A_STAT = 2;
    localparam int A_IEN  = 3;
    localparam int A_FID  = 4;

    localparam int B_EN     = 0;
    localparam int B_MODE   = 1;
    localparam int B_UNLOCK = 4;
    localparam int CNT_LSB  = 8;
    localparam int EV_N     = 2;
endpackage

// File: rtl/capctx_regs.sv
module capctx_regs
    import capctx_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LINE_W = 16,
    parameter int FID_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              frame_start,
    input  logic              cnt_expire,
    input  logic              set_cnt_evt,
    input  logic              set_line_evt,
    input  logic              ctx_on,
    input  logic [CNT_W-1:0]  act_cnt,
    input  logic [FID_W-1:0]  frame_id,
    output logic              pend_en,
    output logic              cnt_ld,
    output logic [CNT_W-1:0]  cnt_ld_val,
    output logic              act_mode,
    output logic [LINE_W-1:0] act_line,
    output logic              irq,
    output logic [DATA_W-1:0] rd_data
);
    logic              pend_mode;
    logic [LINE_W-1:0] pend_line;
    logic [EV_N-1:0]   status;
    logic [EV_N-1:0]   ien;
    logic [EV_N-1:0]   clr_mask;
    logic              wr_ctrl, wr_line, wr_stat, wr_ien;
    logic              unused_wd;

    assign unused_wd = ^wr_data;
    assign wr_ctrl   = wr_en && (wr_addr == ADDR_W'(A_CTRL));
    assign wr_line   = wr_en && (wr_addr == ADDR_W'(A_LINE));
    assign wr_stat   = wr_en && (wr_addr == ADDR_W'(A_STAT));
    assign wr_ien    = wr_en && (wr_addr == ADDR_W'(A_IEN));
    assign clr_mask  = wr_stat ? wr_data[EV_N-1:0] : '0;

    // shadowed control: pending copies, moved to active on frame start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_en    <= 1'b0;
            pend_mode  <= 1'b0;
            pend_line  <= '0;
            cnt_ld     <= 1'b0;
            cnt_ld_val <= '0;
            act_mode   <= 1'b0;
            act_line   <= '0;
        end else begin
            if (frame_start) begin
                act_mode <= pend_mode;
                act_line <= pend_line;
                cnt_ld   <= 1'b0;
            end
            if (wr_ctrl) begin
                pend_en   <= wr_data[B_EN];
                pend_mode <= wr_data[B_MODE];
                if (wr_data[B_UNLOCK]) begin
                    cnt_ld_val <= wr_data[CNT_LSB +: CNT_W];
                    cnt_ld     <= 1'b1;
                end
            end
            if (wr_line)
                pend_line <= wr_data[LINE_W-1:0];
            if (cnt_expire)
                pend_en <= 1'b0;
        end
    end

    // events: set has priority over write-1-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            ien    <= '0;
        end else begin
            status <= (status & ~clr_mask) | {set_line_evt, set_cnt_evt};
            if (wr_ien)
                ien <= wr_data[EV_N-1:0];
        end
    end

    assign irq = |(status & ien);

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_W'(A_CTRL): begin
                rd_data[B_EN]              = ctx_on;
                rd_data[B_MODE]            = act_mode;
                rd_data[CNT_LSB +: CNT_W]  = act_cnt;
            end
            ADDR_W'(A_LINE): rd_data[LINE_W-1:0] = act_line;
            ADDR_W'(A_STAT): rd_data[EV_N-1:0]   = status;
            ADDR_W'(A_IEN):  rd_data[EV_N-1:0]   = ien;
            ADDR_W'(A_FID):  rd_data[FID_W-1:0]  = frame_id;
            default:         rd_data = '0;
        endcase
    end
endmodule

// File: rtl/capctx_fsm.sv
module capctx_fsm
    import capctx_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int FID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic [FID_W-1:0] frame_num_in,
    input  logic             pend_en,
    input  logic             cnt_ld,
    input  logic [CNT_W-1:0] cnt_ld_val,
    output cap_state_e       state,
    output logic             cnt_expire,
    output logic [CNT_W-1:0] act_cnt,
    output logic [FID_W-1:0] frame_id,
    output logic             ev_count
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    cap_state_e nxt;
    logic       end_of_capt;

    assign end_of_capt = (state == S_CAPT) && frame_end && !frame_start;
    assign cnt_expire  = end_of_capt && (act_cnt == CNT_ONE);

    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF, S_IDLE: begin
                if (frame_start)
                    nxt = pend_en ? S_CAPT : S_OFF;
            end
            S_CAPT: begin
                if (frame_start)
                    nxt = pend_en ? S_CAPT : S_OFF;
                else if (frame_end)
                    nxt = cnt_expire ? S_OFF : S_IDLE;
            end
            default: nxt = S_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_OFF;
        else
            state <= nxt;
    end

    // outputs: remaining count, frame identifier, quota event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cnt  <= '0;
            frame_id <= '0;
            ev_count <= 1'b0;
        end else begin
            ev_count <= cnt_expire;
            if (frame_start) begin
                if (cnt_ld)
                    act_cnt <= cnt_ld_val;
                if (pend_en)
                    frame_id <= frame_num_in;
            end else if (end_of_capt && act_cnt != '0) begin
                act_cnt <= act_cnt - CNT_ONE;
            end
        end
    end
endmodule

// File: rtl/capctx_line.sv
module capctx_line #(
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_end,
    input  logic              in_capt,
    input  logic              mode_mod,
    input  logic [LINE_W-1:0] line_pos,
    output logic              ev_line
);
    localparam logic [LINE_W-1:0] LN_MAX = '1;

    logic [LINE_W-1:0] ln_cnt;
    logic [LINE_W:0]   ln_next;
    logic              step, hit;

    assign step    = line_end && in_capt && !frame_start;
    assign ln_next = {1'b0, ln_cnt} + 1'b1;
    assign hit     = (line_pos != '0) && (ln_next == {1'b0, line_pos});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_cnt  <= '0;
            ev_line <= 1'b0;
        end else begin
            ev_line <= step && hit;
            if (frame_start)
                ln_cnt <= '0;
            else if (step) begin
                if (hit && mode_mod)
                    ln_cnt <= '0;
                else if (ln_cnt != LN_MAX)
                    ln_cnt <= ln_next[LINE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/capctx_ctrl.sv
module capctx_ctrl
    import capctx_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LINE_W = 16,
    parameter int FID_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              line_end,
    input  logic [FID_W-1:0]  frame_num_in,
    output logic              capturing,
    output logic [FID_W-1:0]  frame_id,
    output logic              ev_count,
    output logic              ev_line,
    output logic              irq
);
    cap_state_e        state;
    logic              pend_en, cnt_ld, cnt_expire, act_mode;
    logic [CNT_W-1:0]  cnt_ld_val, act_cnt;
    logic [LINE_W-1:0] act_line;

    assign capturing = (state == S_CAPT);

    capctx_regs #(
        .CNT_W(CNT_W), .LINE_W(LINE_W), .FID_W(FID_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .frame_start(frame_start), .cnt_expire(cnt_expire),
        .set_cnt_evt(ev_count), .set_line_evt(ev_line),
        .ctx_on(state != S_OFF), .act_cnt(act_cnt), .frame_id(frame_id),
        .pend_en(pend_en), .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val),
        .act_mode(act_mode), .act_line(act_line),
        .irq(irq), .rd_data(rd_data)
    );

    capctx_fsm #(.CNT_W(CNT_W), .FID_W(FID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .frame_end(frame_end), .frame_num_in(frame_num_in),
        .pend_en(pend_en), .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val),
        .state(state), .cnt_expire(cnt_expire), .act_cnt(act_cnt),
        .frame_id(frame_id), .ev_count(ev_count)
    );

    capctx_line #(.LINE_W(LINE_W)) u_line (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .line_end(line_end), .in_capt(capturing),
        .mode_mod(act_mode), .line_pos(act_line), .ev_line(ev_line)
    );
endmodule

// File: rtl/capctx_chk.sv
module capctx_chk #(
    parameter int CNT_W = 8,
    parameter int FID_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             capturing,
    input logic             ev_count,
    input logic             ev_line,
    input logic [CNT_W-1:0] act_cnt,
    input logic [FID_W-1:0] frame_id
);
    AST_QUOTA_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_count |-> !capturing);  // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(frame_start) && act_cnt != $past(act_cnt))
            |-> act_cnt == CNT_W'($past(act_cnt) - 1'b1));  // R4

    AST_UNLIMITED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cnt == '0 && !frame_start) |=> act_cnt == '0);  // R5

    AST_LINE_IN_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_line |-> $past(capturing));  // R7

    AST_FID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |-> $stable(frame_id));  // R9
endmodule

bind capctx_ctrl capctx_chk #(.CNT_W(CNT_W), .FID_W(FID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .capturing(capturing),
    .ev_count(ev_count), .ev_line(ev_line), .act_cnt(act_cnt), .frame_id(frame_id)
);

// File: tb/tb_capctx_ctrl.sv
module tb_capctx_ctrl;
    localparam int CNT_W = 8, LINE_W = 6, FID_W = 8, DATA_W = 32, ADDR_W = 3;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [DATA_W-1:0] wr_data = '0, rd_data;
    logic frame_start = 0, frame_end = 0, line_end = 0;
    logic [FID_W-1:0] frame_num_in = '0, frame_id;
    logic capturing, ev_count, ev_line, irq;

    int checks = 0, errors = 0;
    int n_line = 0, n_cnt = 0;
    logic last_cap;

    always #5 clk = ~clk;

    capctx_ctrl #(.CNT_W(CNT_W), .LINE_W(LINE_W), .FID_W(FID_W),
                  .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .frame_start(frame_start),
        .frame_end(frame_end), .line_end(line_end), .frame_num_in(frame_num_in),
        .capturing(capturing), .frame_id(frame_id), .ev_count(ev_count),
        .ev_line(ev_line), .irq(irq));

    always @(negedge clk) begin
        if (ev_line)  n_line++;
        if (ev_count) n_cnt++;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string req);
        rd_addr = ADDR_W'(a);
        #1;
        check(rd_data == DATA_W'(exp), req, rd_data, exp);
    endtask

    task automatic pulse_fs(input int fid);
        @(negedge clk);
        frame_start = 1; frame_num_in = FID_W'(fid);
        @(negedge clk);
        frame_start = 0;
        last_cap = capturing;
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); line_end = 1;
            @(negedge clk); line_end = 0;
        end
    endtask

    task automatic pulse_fe();
        @(negedge clk); frame_end = 1;
        @(negedge clk); frame_end = 0;
        @(negedge clk);
    endtask

    task automatic frame(input int fid, input int n);
        pulse_fs(fid);
        lines(n);
        pulse_fe();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int b, cap, exp;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(!capturing && !irq && !ev_count && !ev_line, "R1 outputs", {capturing, irq}, 0);
        for (int a = 0; a < 5; a++) rd_chk(a, 0, "R1 register");

        // R6: frame already running when enabled is ignored
        pulse_fs(9);
        check(capturing == 0, "R6 off at start", capturing, 0);
        wr(1, 2);
        wr(0, 1);
        rd_chk(0, 0, "R2 ctrl shadowed");
        rd_chk(1, 0, "R2 line shadowed");
        b = n_line;
        lines(3);
        pulse_fe();
        check(capturing == 0, "R6 running frame ignored", capturing, 0);
        check(n_line == b, "R6 no line event", n_line - b, 0);
        b = n_line;
        frame(4, 3);
        check(last_cap == 1, "R6 capture at next start", last_cap, 1);
        rd_chk(0, 1, "R2 ctrl applied");
        rd_chk(1, 2, "R2 line applied");
        check(n_line - b == 1, "R7 line hit", n_line - b, 1);

        // R3: count ignored without unlock; R5 unlimited
        wr(0, 1 | (5 << 8));
        frame(1, 2);
        rd_chk(0, 1, "R3 locked count write");
        b = n_cnt; cap = 0;
        for (int f = 0; f < 4; f++) begin frame(f, 1); cap += int'(last_cap); end
        check(cap == 4, "R5 unlimited frames", cap, 4);
        check(n_cnt == b, "R5 no count event", n_cnt - b, 0);
        rd_chk(0, 1, "R5 count unchanged");
        wr(2, 3);

        // R4: quota sweep
        for (int n = 1; n <= 4; n++) begin
            wr(0, 1 | 16 | (n << 8));
            b = n_cnt; cap = 0;
            for (int f = 0; f < n + 2; f++) begin
                frame(f, 1);
                cap += int'(last_cap);
                if (f == 0) rd_chk(0, (n > 1) ? (1 | ((n - 1) << 8)) : 0, "R4 decrement");
            end
            check(cap == n, "R4 frames captured", cap, n);
            check(n_cnt - b == 1, "R4 one count event", n_cnt - b, 1);
            rd_chk(0, 0, "R4 self disable");
            rd_addr = 3'(2); #1;
            check(rd_data[0] == 1'b1, "R4 status bit0", rd_data[0], 1);
            wr(2, 3);
        end

        // R7: mode 0 sweep, 7 lines per frame
        for (int l = 0; l <= 9; l++) begin
            wr(1, l);
            wr(0, 1);
            b = n_line;
            frame(l, 7);
            exp = (l >= 1 && l <= 7) ? 1 : 0;
            check(n_line - b == exp, "R7 mode0 hits", n_line - b, exp);
        end

        // R8: mode 1 sweep, 12 lines per frame
        for (int l = 0; l <= 13; l++) begin
            wr(1, l);
            wr(0, 3);
            b = n_line;
            frame(l, 12);
            exp = (l == 0) ? 0 : 12 / l;
            check(n_line - b == exp, "R8 mode1 hits", n_line - b, exp);
        end

        // R9: frame identifier
        wr(0, 1);
        pulse_fs(8'hA5);
        check(frame_id == 8'hA5, "R9 id port", frame_id, 8'hA5);
        rd_chk(4, 8'hA5, "R9 id register");
        pulse_fe();
        wr(0, 0);
        frame(8'h3C, 0);
        check(frame_id == 8'hA5 && !last_cap, "R9 id kept when off", frame_id, 8'hA5);

        // R10: status clear and interrupt gating
        wr(2, 3);
        rd_chk(2, 0, "R10 status cleared");
        wr(3, 0);
        wr(1, 1);
        wr(0, 1);
        frame(2, 1);
        rd_chk(2, 2, "R10 line status set");
        check(irq == 0, "R10 irq masked", irq, 0);
        wr(3, 2);
        check(irq == 1, "R10 irq enabled", irq, 1);
        wr(2, 1);
        check(irq == 1, "R10 clear other bit", irq, 1);
        rd_chk(2, 2, "R10 status kept");
        wr(2, 2);
        check(irq == 0, "R10 irq after clear", irq, 0);
        rd_chk(2, 0, "R10 status empty");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule